// File: doc/BRIEF.md
# Shift-Subtract Remainder Unit

This block returns the remainder of an unsigned dividend divided by an unsigned, nonzero divisor. It holds both operands in working registers one bit wider than the data, so that the spare top bit can show the sign of a trial difference. It uses only an adder/subtractor, a one-bit shifter and a small up/down counter. A Moore controller sequences the work one register update per clock.

When a start pulse arrives while the unit is idle, both operands are captured. The divisor register is first shifted left until its most significant data bit is set, and each shift is counted. The unit then repeats one reduction step. It subtracts the divisor register from the remainder register, adds it back if the difference came out negative, and stops if the shift count has returned to zero. Otherwise it shifts the divisor back right, decrements the count and repeats. When the loop ends, a single-cycle done strobe comes out and the remainder is presented on the result port.

Top module: `rem_unit`

## Requirements
- R1: A synchronous active-high reset, even one applied in the middle of an operation, clears the working registers and the shift counter and returns the controller to idle. After reset, done is 0, rem is 0 and the next start is accepted.
- R2: For any dividend and any nonzero divisor, the rem value presented while done is high equals dividend modulo divisor.
- R3: A dividend smaller than the divisor comes back unchanged, and a dividend equal to the divisor gives 0.
- R4: Both operands are sampled at the clock edge where start is seen in the idle state. Later changes on the operand inputs do not affect the result.
- R5: A start pulse that arrives while an operation is in progress is ignored. It yields no additional done and does not alter the pending result.
- R6: done is high for exactly one cycle, once per accepted start.
- R7: Normalisation shifts the divisor left, with a 0 entering at the bottom, until bit W-1 of the divisor register is 1. The counter counts these shifts. A divisor that already has its top bit set takes no shifts, and a divisor of 1 takes W-1 shifts. The counter is back at zero when done rises.
- R8: A subtraction whose 9th (sign) bit comes out 1 is undone by adding the divisor back. The remainder register is never negative for more than the two cycles that the test and the restore take.
- R9: The arithmetic unit select encodes 00 as add, 01 as subtract, 10 as shift the divisor left and 11 as shift the divisor right, with zero fill in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; honoured only when idle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor, nonzero |
| done | output | 1 | One-cycle completion strobe |
| rem | output | W | Remainder, valid while done is high |

## Verification
The bench builds two copies of the block. The first uses W=8. It sweeps every dividend from 1 to 255 against divisors chosen to need the most normalisation shifts (1), none (128 and 255), and a mix in between. It also covers mid-operation start and operand changes, and a reset during an operation. The second copy uses W=4, which makes the exhaustive sweep of all 15×15 operand pairs short enough to run. That brings every restore and shift path of a full-width divide within reach.

// File: rtl/rem_pkg.sv
package rem_pkg;

    // Arithmetic unit operation select
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_SHL = 2'b10,
        OP_SHR = 2'b11
    } alu_op_e;

    // Controller states: one register update or one test per state
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NTST,
        ST_SHL,
        ST_SUB,
        ST_STST,
        ST_RSTR,
        ST_CTST,
        ST_SHR,
        ST_DONE
    } state_e;

    // Control word from the controller to the datapath
    typedef struct packed {
        alu_op_e op;
        logic    a_we;
        logic    b_we;
        logic    cnt_en;
        logic    cnt_dn;
        logic    ld_ok;
        logic    done;
    } ctl_t;

    // Status bits from the datapath to the controller
    typedef struct packed {
        logic b_top;
        logic a_neg;
        logic cnt_zero;
    } stat_t;

    function automatic int cnt_bits(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/rem_alu.sv
module rem_alu
    import rem_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W:0] a,
    input  logic [W:0] b,
    input  alu_op_e    op,
    output logic [W:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_SHL:  y = {b[W-1:0], 1'b0};
            default: y = {1'b0, b[W:1]};
        endcase
    end
endmodule

// File: rtl/rem_updn_cnt.sv
module rem_updn_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          dn,
    output logic [CW-1:0] q,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= dn ? q - 1'b1 : q + 1'b1;
    end

    assign zero = (q == '0);
endmodule

// File: rtl/rem_ctrl.sv
module rem_ctrl
    import rem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  stat_t st,
    output ctl_t  ctl
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_NTST;
            ST_NTST: state_d = st.b_top ? ST_SUB : ST_SHL;
            ST_SHL:  state_d = ST_NTST;
            ST_SUB:  state_d = ST_STST;
            ST_STST: state_d = st.a_neg ? ST_RSTR : ST_CTST;
            ST_RSTR: state_d = ST_CTST;
            ST_CTST: state_d = st.cnt_zero ? ST_DONE : ST_SHR;
            ST_SHR:  state_d = ST_SUB;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs: a function of the present state only
    always_comb begin
        ctl = '0;
        ctl.op = OP_ADD;
        case (state_q)
            ST_IDLE: ctl.ld_ok = 1'b1;
            ST_SHL: begin
                ctl.op = OP_SHL; ctl.b_we = 1'b1; ctl.cnt_en = 1'b1;
            end
            ST_SUB: begin
                ctl.op = OP_SUB; ctl.a_we = 1'b1;
            end
            ST_RSTR: begin
                ctl.op = OP_ADD; ctl.a_we = 1'b1;
            end
            ST_SHR: begin
                ctl.op = OP_SHR; ctl.b_we = 1'b1;
                ctl.cnt_en = 1'b1; ctl.cnt_dn = 1'b1;
            end
            ST_DONE: ctl.done = 1'b1;
            default: ;
        endcase
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done);

endmodule

// File: rtl/rem_unit.sv
module rem_unit
    import rem_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] rem
);
    localparam int CW = cnt_bits(W);

    logic [W:0]    a_q, b_q, alu_y;
    logic [CW-1:0] cnt_q;
    logic          cnt_zero;
    ctl_t          ctl;
    stat_t         st;

    rem_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .st    (st),
        .ctl   (ctl)
    );

    rem_alu #(.W(W)) u_alu (
        .a  (a_q),
        .b  (b_q),
        .op (ctl.op),
        .y  (alu_y)
    );

    rem_updn_cnt #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (ctl.cnt_en),
        .dn   (ctl.cnt_dn),
        .q    (cnt_q),
        .zero (cnt_zero)
    );

    // Working registers with sign bit
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (ctl.ld_ok && start) begin
            a_q <= {1'b0, dividend};
            b_q <= {1'b0, divisor};
        end else begin
            if (ctl.a_we) a_q <= alu_y;
            if (ctl.b_we) b_q <= alu_y;
        end
    end

    assign st.b_top    = b_q[W-1];
    assign st.a_neg    = a_q[W];
    assign st.cnt_zero = cnt_zero;

    assign done = ctl.done;
    assign rem  = a_q[W-1:0];

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.ld_ok && start) |=> (a_q == {1'b0, $past(dividend)}));

    // R2
    rem_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!a_q[W] && (a_q < b_q)));

    // R7
    cnt_home_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_q == '0));

    // R8
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a_q[W]) |-> ##2 !a_q[W]);

endmodule

// File: tb/sim_rem_unit.sv
module sim_rem_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic       st0 = 1'b0, done0;
    logic [7:0] dd0 = '0, dv0 = 8'd1, rem0;
    logic       st1 = 1'b0, done1;
    logic [3:0] dd1 = '0, dv1 = 4'd1, rem1;

    rem_unit #(.W(8)) u0 (.clk(clk), .rst(rst), .start(st0), .dividend(dd0),
                          .divisor(dv0), .done(done0), .rem(rem0));
    rem_unit #(.W(4)) u1 (.clk(clk), .rst(rst), .start(st1), .dividend(dd1),
                          .divisor(dv1), .done(done1), .rem(rem1));

    int    q0[$], q1[$];
    string t0[$], t1[$];
    int    pushed0 = 0, seen0 = 0;
    logic  prev0 = 1'b0, prev1 = 1'b0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // Monitors: pop the expected item when a result appears
    always @(negedge clk) begin
        if (!rst) begin
            if (done0) begin
                seen0++;
                if (q0.size() == 0) chk(1'b0, "R5 unexpected done", 1, 0);
                else begin
                    int e; string t;
                    e = q0.pop_front(); t = t0.pop_front();
                    chk(rem0 == e[7:0], t, int'(rem0), e);
                end
            end
            if (done0 && prev0) chk(1'b0, "R6 done held two cycles", 2, 1);
            if (done1) begin
                if (q1.size() == 0) chk(1'b0, "R5 unexpected done w4", 1, 0);
                else begin
                    int e; string t;
                    e = q1.pop_front(); t = t1.pop_front();
                    chk(rem1 == e[3:0], t, int'(rem1), e);
                end
            end
            if (done1 && prev1) chk(1'b0, "R6 done held two cycles w4", 2, 1);
        end
        prev0 = done0;
        prev1 = done1;
    end

    task automatic op0(input int a, input int b, input string r);
        q0.push_back(a % b); t0.push_back(r); pushed0++;
        @(negedge clk); dd0 = a[7:0]; dv0 = b[7:0]; st0 = 1'b1;
        @(negedge clk); st0 = 1'b0;
        do @(negedge clk); while (!done0);
    endtask

    task automatic op1(input int a, input int b, input string r);
        q1.push_back(a % b); t1.push_back(r);
        @(negedge clk); dd1 = a[3:0]; dv1 = b[3:0]; st1 = 1'b1;
        @(negedge clk); st1 = 1'b0;
        do @(negedge clk); while (!done1);
    endtask

    function automatic string tag_for(input int a, input int b, input int top);
        if (a <= b) return "R3 small or equal dividend";
        if (b == 1 || b >= top) return "R7 normalisation extremes";
        if (b == 3) return "R8 restore path";
        return "R2 remainder";
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++; errors++;
            $display("FAIL R6 watchdog: no completion actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    initial begin
        int divs[6] = '{1, 3, 128, 255, 17, 100};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done0 == 1'b0, "R1 done after reset", int'(done0), 0);
        chk(rem0 == 8'd0, "R1 rem after reset", int'(rem0), 0);

        // R9: results depend on correct add/sub/shift encodings
        op0(200, 7, "R9 alu ops 200 mod 7");
        op0(255, 255, "R3 equal operands");
        op0(5, 200, "R3 dividend below divisor");
        op0(255, 1, "R7 divisor one");
        op0(254, 128, "R7 divisor top bit set");

        // R4 / R5: operand change and start while busy
        q0.push_back(4); t0.push_back("R4 R5 busy start and operand change"); pushed0++;
        @(negedge clk); dd0 = 8'd200; dv0 = 8'd7; st0 = 1'b1;
        @(negedge clk); st0 = 1'b0; dd0 = 8'd9;
        repeat (3) @(negedge clk);
        st0 = 1'b1; dd0 = 8'd50;
        @(negedge clk); st0 = 1'b0;
        do @(negedge clk); while (!done0);
        repeat (120) @(negedge clk);
        chk(q0.size() == 0, "R5 pending items after busy start", q0.size(), 0);
        chk(seen0 == pushed0, "R6 one done per start", seen0, pushed0);

        // R1: reset in the middle of an operation
        @(negedge clk); dd0 = 8'd250; dv0 = 8'd3; st0 = 1'b1;
        @(negedge clk); st0 = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done0 == 1'b0, "R1 done after mid-op reset", int'(done0), 0);
        chk(rem0 == 8'd0, "R1 rem after mid-op reset", int'(rem0), 0);
        repeat (80) @(negedge clk);
        chk(seen0 == pushed0, "R1 no done from aborted op", seen0, pushed0);
        op0(77, 10, "R1 start accepted after reset");

        // Sweep at W=8
        foreach (divs[i])
            for (int a = 1; a <= 255; a++)
                op0(a, divs[i], tag_for(a, divs[i], 128));

        // Exhaustive at W=4
        for (int b = 1; b <= 15; b++)
            for (int a = 1; a <= 15; a++)
                op1(a, b, tag_for(a, b, 8));

        repeat (4) @(negedge clk);
        chk(q0.size() == 0, "R6 results outstanding w8", q0.size(), 0);
        chk(q1.size() == 0, "R6 results outstanding w4", q1.size(), 0);
        finish_run();
    end
endmodule